// File: doc/BRIEF.md
# Debug Hart Flag Mailbox

This block is the shared mailbox between a debug module and the harts that run its debug ROM while halted. The debugger asks a hart to execute a command by raising that hart's GO request, and it releases one or more harts by raising their RESUME requests. Each hart polls its own flag byte with a byte load. It answers by storing its own hart ID to a small set of fixed acknowledge addresses. Those stores mark the hart as halted, retire its GO request, or retire its RESUME request and mark it as running again.

A store of any value to the exception address raises a sticky exception indication toward the debugger. The indication stays raised until the debugger acknowledges it. All hart-side traffic arrives on a simple word bus with one request per cycle. Read data comes back from a register one cycle after the request. The debugger side uses single-cycle request strobes, and the state is visible as per-hart status vectors.

Top module: `dbg_flag_mailbox`

## Requirements
- R1: After reset, every GO flag, RESUME flag and halted bit is 0, the exception indication is 0, and `bus_rdata` is 0.
- R2: A cycle with `dbg_go_req` high sets the GO flag (flag bit 0) of hart `dbg_go_hart`, where that index is below NHARTS, from the next cycle on. Every other hart's GO flag is left unchanged.
- R3: Each bit set in `dbg_resume_req` sets the RESUME flag (flag bit 1) of that hart from the next cycle on. Several harts can be set in the same cycle.
- R4: A store to offset 0x100 whose data is a hart ID below NHARTS sets that hart's halted bit from the next cycle on.
- R5: A store of a valid hart ID to offset 0x104 clears that hart's GO flag from the next cycle on. It leaves that hart's RESUME flag and halted bit unchanged.
- R6: A store of a valid hart ID to offset 0x108 clears that hart's RESUME flag and its halted bit from the next cycle on.
- R7: When a debugger set and a hart clearing store target the same flag of the same hart in one cycle, the flag ends up 0.
- R8: A store of any data to offset 0x10C raises `dbg_exception` from the next cycle on. It stays high until a cycle with `dbg_exc_ack` and no such store. If a store and an acknowledge fall in the same cycle, the indication is 1 afterwards.
- R9: A read at address A in 0x400..0x7FF returns, in the cycle after the request, a word whose byte lane k holds the flag byte of hart 4*A[9:2]+k. In that byte, bit 0 is GO, bit 1 is RESUME and bits 7:2 are 0. A lane whose hart index is NHARTS or above reads 0. The value reflects the flags as they were before that cycle's updates.
- R10: A read anywhere outside the flag array returns 0 in the cycle after the request. Stores to the flag array or to any unlisted address change no flag, no halted bit and no exception state.
- R11: A store to 0x100, 0x104 or 0x108 whose data is NHARTS or larger changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Hart bus request valid |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte address within the debug region |
| bus_wdata | input | DATA_W | Store data (hart ID for acknowledge stores) |
| bus_rdata | output | DATA_W | Load data, one cycle after the request |
| dbg_go_req | input | 1 | Debugger strobe: set GO of one hart |
| dbg_go_hart | input | ID_W | Hart targeted by `dbg_go_req` |
| dbg_resume_req | input | NHARTS | Debugger strobes: set RESUME per hart |
| dbg_exc_ack | input | 1 | Debugger strobe: clear the exception indication |
| flag_go | output | NHARTS | Current GO flags |
| flag_resume | output | NHARTS | Current RESUME flags |
| hart_halted | output | NHARTS | Per-hart halted status |
| dbg_exception | output | 1 | Sticky exception indication |

## Verification
Every result is due exactly one clock edge after the cycle that causes it. This covers flag and halted updates, the exception indication, and load data, which is registered from the flags as they stood before that edge. The bench drives inputs on the falling edge and advances a reference model by one step per rising edge. It compares all outputs on the next falling edge, so each check lands on the cycle right after its stimulus. Directed cycles cover a set colliding with a clear, an exception store colliding with its acknowledge, out-of-range IDs and the empty upper byte lanes.

// File: rtl/dbg_mbox_pkg.sv
package dbg_mbox_pkg;

    // Offsets inside the debug region (byte addresses)
    localparam int unsigned OFS_HALTED    = 'h100;
    localparam int unsigned OFS_GOING     = 'h104;
    localparam int unsigned OFS_RESUMING  = 'h108;
    localparam int unsigned OFS_EXCEPTION = 'h10C;
    localparam int unsigned FLAG_BASE     = 'h400;
    localparam int unsigned FLAG_SPAN     = 'h400;

    // Bit positions inside a flag byte
    localparam int unsigned GO_BIT     = 0;
    localparam int unsigned RESUME_BIT = 1;

    // One decoded hart-bus event per cycle
    typedef struct packed {
        logic mark_halted;
        logic clr_go;
        logic clr_resume;
        logic raise_exc;
        logic flag_rd;
    } bus_evt_t;

endpackage

// File: rtl/dbg_mbox_decode.sv
module dbg_mbox_decode
    import dbg_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NHARTS = 6,
    parameter int unsigned ID_W   = 3,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output bus_evt_t          evt,
    output logic [ID_W-1:0]   evt_id,
    output logic [IDX_W-1:0]  rd_word
);

    logic store;
    logic load;
    logic id_ok;
    logic in_flags;

    always_comb begin
        store    = bus_req && bus_we;
        load     = bus_req && !bus_we;
        id_ok    = (bus_wdata < DATA_W'(NHARTS));
        in_flags = (bus_addr >= ADDR_W'(FLAG_BASE)) &&
                   (bus_addr <  ADDR_W'(FLAG_BASE + FLAG_SPAN));

        evt             = '0;
        evt.mark_halted = store && id_ok && (bus_addr == ADDR_W'(OFS_HALTED));
        evt.clr_go      = store && id_ok && (bus_addr == ADDR_W'(OFS_GOING));
        evt.clr_resume  = store && id_ok && (bus_addr == ADDR_W'(OFS_RESUMING));
        evt.raise_exc   = store && (bus_addr == ADDR_W'(OFS_EXCEPTION));
        evt.flag_rd     = load && in_flags;

        evt_id  = bus_wdata[ID_W-1:0];
        rd_word = bus_addr[IDX_W+1:2];
    end

endmodule

// File: rtl/dbg_mbox_hart_flags.sv
module dbg_mbox_hart_flags
    import dbg_mbox_pkg::*;
#(
    parameter int unsigned NHARTS = 6,
    parameter int unsigned ID_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [ID_W-1:0]   evt_id,
    input  logic              go_req,
    input  logic [ID_W-1:0]   go_hart,
    input  logic [NHARTS-1:0] resume_req,
    output logic [NHARTS-1:0] go_o,
    output logic [NHARTS-1:0] resume_o,
    output logic [NHARTS-1:0] halted_o
);

    typedef struct packed {
        logic [NHARTS-1:0] go;
        logic [NHARTS-1:0] resume;
        logic [NHARTS-1:0] halted;
    } flag_state_t;

    flag_state_t state_d, state_q;

    logic [NHARTS-1:0] go_nx;
    logic [NHARTS-1:0] resume_nx;
    logic [NHARTS-1:0] halted_nx;

    // Per-hart next-state slice; clear wins over set
    for (genvar h = 0; h < NHARTS; h++) begin : g_hart
        logic sel;
        logic go_set;
        assign sel    = (evt_id == ID_W'(h));
        assign go_set = go_req && (go_hart == ID_W'(h));

        always_comb begin
            go_nx[h] = state_q.go[h];
            if (go_set)
                go_nx[h] = 1'b1;
            if (evt.clr_go && sel)
                go_nx[h] = 1'b0;

            resume_nx[h] = state_q.resume[h];
            if (resume_req[h])
                resume_nx[h] = 1'b1;
            if (evt.clr_resume && sel)
                resume_nx[h] = 1'b0;

            halted_nx[h] = state_q.halted[h];
            if (evt.mark_halted && sel)
                halted_nx[h] = 1'b1;
            if (evt.clr_resume && sel)
                halted_nx[h] = 1'b0;
        end
    end

    always_comb begin
        state_d        = state_q;
        state_d.go     = go_nx;
        state_d.resume = resume_nx;
        state_d.halted = halted_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign go_o     = state_q.go;
    assign resume_o = state_q.resume;
    assign halted_o = state_q.halted;

endmodule

// File: rtl/dbg_mbox_readback.sv
module dbg_mbox_readback
    import dbg_mbox_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NHARTS = 6,
    parameter int unsigned IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_rd,
    input  logic [IDX_W-1:0]  rd_word,
    input  logic [NHARTS-1:0] go_i,
    input  logic [NHARTS-1:0] resume_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned LANES  = DATA_W / 8;
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned HIDX_W = IDX_W + LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rb_state_t;

    rb_state_t state_d, state_q;
    logic [DATA_W-1:0] word_nx;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [HIDX_W-1:0] lane_hart;
        logic [7:0]        lane_byte;
        assign lane_hart = {rd_word, LANE_W'(k)};

        always_comb begin
            lane_byte = '0;
            for (int h = 0; h < NHARTS; h++) begin
                if (lane_hart == HIDX_W'(h)) begin
                    lane_byte[GO_BIT]     = go_i[h];
                    lane_byte[RESUME_BIT] = resume_i[h];
                end
            end
        end

        assign word_nx[8*k +: 8] = lane_byte;
    end

    always_comb begin
        state_d       = state_q;
        state_d.rdata = flag_rd ? word_nx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign rdata_o = state_q.rdata;

endmodule

// File: rtl/dbg_flag_mailbox.sv
module dbg_flag_mailbox
    import dbg_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NHARTS = 6,
    parameter int unsigned ID_W   = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_go_req,
    input  logic [ID_W-1:0]   dbg_go_hart,
    input  logic [NHARTS-1:0] dbg_resume_req,
    input  logic              dbg_exc_ack,
    output logic [NHARTS-1:0] flag_go,
    output logic [NHARTS-1:0] flag_resume,
    output logic [NHARTS-1:0] hart_halted,
    output logic              dbg_exception
);

    localparam int unsigned IDX_W = $clog2(FLAG_SPAN) - 2;

    typedef struct packed {
        logic exc;
    } top_state_t;

    bus_evt_t          evt;
    logic [ID_W-1:0]   evt_id;
    logic [IDX_W-1:0]  rd_word;
    top_state_t        state_d, state_q;

    dbg_mbox_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NHARTS (NHARTS),
        .ID_W   (ID_W),
        .IDX_W  (IDX_W)
    ) i_decode (
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt       (evt),
        .evt_id    (evt_id),
        .rd_word   (rd_word)
    );

    dbg_mbox_hart_flags #(
        .NHARTS (NHARTS),
        .ID_W   (ID_W)
    ) i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .evt_id     (evt_id),
        .go_req     (dbg_go_req),
        .go_hart    (dbg_go_hart),
        .resume_req (dbg_resume_req),
        .go_o       (flag_go),
        .resume_o   (flag_resume),
        .halted_o   (hart_halted)
    );

    dbg_mbox_readback #(
        .DATA_W (DATA_W),
        .NHARTS (NHARTS),
        .IDX_W  (IDX_W)
    ) i_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_rd  (evt.flag_rd),
        .rd_word  (rd_word),
        .go_i     (flag_go),
        .resume_i (flag_resume),
        .rdata_o  (bus_rdata)
    );

    // Sticky exception: a new exception store outranks the acknowledge
    always_comb begin
        state_d = state_q;
        if (dbg_exc_ack)
            state_d.exc = 1'b0;
        if (evt.raise_exc)
            state_d.exc = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign dbg_exception = state_q.exc;

endmodule

// File: rtl/dbg_mbox_checker.sv
module dbg_mbox_checker
    import dbg_mbox_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NHARTS = 6,
    parameter int unsigned ID_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              dbg_go_req,
    input logic [ID_W-1:0]   dbg_go_hart,
    input logic [NHARTS-1:0] dbg_resume_req,
    input logic              dbg_exc_ack,
    input logic [NHARTS-1:0] flag_go,
    input logic [NHARTS-1:0] flag_resume,
    input logic [NHARTS-1:0] hart_halted,
    input logic              dbg_exception
);

    logic st_ok;
    logic hit_halt, hit_going, hit_resuming, hit_exc, rd_other;

    always_comb begin
        st_ok        = bus_req && bus_we && (bus_wdata < DATA_W'(NHARTS));
        hit_halt     = st_ok && (bus_addr == ADDR_W'(OFS_HALTED));
        hit_going    = st_ok && (bus_addr == ADDR_W'(OFS_GOING));
        hit_resuming = st_ok && (bus_addr == ADDR_W'(OFS_RESUMING));
        hit_exc      = bus_req && bus_we && (bus_addr == ADDR_W'(OFS_EXCEPTION));
        rd_other     = bus_req && !bus_we &&
                       ((bus_addr < ADDR_W'(FLAG_BASE)) ||
                        (bus_addr >= ADDR_W'(FLAG_BASE + FLAG_SPAN)));
    end

    AST_HALT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_halt |=> hart_halted[$past(bus_wdata[ID_W-1:0])]); // R4

    AST_GOING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_going |=> !flag_go[$past(bus_wdata[ID_W-1:0])]); // R5

    AST_RESUMING_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_resuming |=> !flag_resume[$past(bus_wdata[ID_W-1:0])] &&
                         !hart_halted[$past(bus_wdata[ID_W-1:0])]); // R6

    AST_GO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_go_req && (dbg_go_hart < ID_W'(NHARTS)) && !hit_going)
        |=> flag_go[$past(dbg_go_hart)]); // R2

    AST_RESUME_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dbg_resume_req) && !hit_resuming)
        |=> ((flag_resume & $past(dbg_resume_req)) == $past(dbg_resume_req))); // R3

    AST_EXC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_exc |=> dbg_exception); // R8

    AST_EXC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_exception && !dbg_exc_ack) |=> dbg_exception); // R8

    AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |=> (bus_rdata == '0)); // R10

    AST_NO_STRAY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_halt) |=> ((hart_halted & ~$past(hart_halted)) == '0)); // R11

endmodule

bind dbg_flag_mailbox dbg_mbox_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NHARTS (NHARTS),
    .ID_W   (ID_W)
) i_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .dbg_go_req     (dbg_go_req),
    .dbg_go_hart    (dbg_go_hart),
    .dbg_resume_req (dbg_resume_req),
    .dbg_exc_ack    (dbg_exc_ack),
    .flag_go        (flag_go),
    .flag_resume    (flag_resume),
    .hart_halted    (hart_halted),
    .dbg_exception  (dbg_exception)
);

// File: tb/test_dbg_flag_mailbox.sv
module test_dbg_flag_mailbox;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned NH     = 6;
    localparam int unsigned ID_W   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              dbg_go_req = 1'b0;
    logic [ID_W-1:0]   dbg_go_hart = '0;
    logic [NH-1:0]     dbg_resume_req = '0;
    logic              dbg_exc_ack = 1'b0;
    logic [NH-1:0]     flag_go, flag_resume, hart_halted;
    logic              dbg_exception;

    int checks = 0;
    int failures = 0;

    // reference model
    logic [NH-1:0]     m_go = '0, m_res = '0, m_halt = '0;
    logic              m_exc = 1'b0;
    logic [DATA_W-1:0] m_rdata = '0;

    always #10 clk = ~clk;

    dbg_flag_mailbox #(
        .ADDR_W (ADDR_W), .DATA_W (DATA_W), .NHARTS (NH), .ID_W (ID_W)
    ) i_dbg_flag_mailbox (
        .clk (clk), .rst_n (rst_n),
        .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .dbg_go_req (dbg_go_req), .dbg_go_hart (dbg_go_hart),
        .dbg_resume_req (dbg_resume_req), .dbg_exc_ack (dbg_exc_ack),
        .flag_go (flag_go), .flag_resume (flag_resume),
        .hart_halted (hart_halted), .dbg_exception (dbg_exception)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: lane k of word w is hart 4*w+k; bit0 GO, bit1 RESUME
    function automatic logic [31:0] flag_word(input logic [ADDR_W-1:0] a);
        logic [31:0] w = '0;
        for (int k = 0; k < 4; k++) begin
            int h = 4 * int'(a[9:2]) + k;
            if (h < NH) w[8*k +: 8] = {6'b0, m_res[h], m_go[h]};
        end
        return w;
    endfunction

    task automatic idle_inputs();
        bus_req = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        dbg_go_req = 0; dbg_go_hart = '0; dbg_resume_req = '0; dbg_exc_ack = 0;
    endtask

    // one clock: model step, then compare all outputs at the next falling edge
    task automatic tick(input string tag);
        logic st, ok;
        logic [ID_W-1:0] id;
        logic [NH-1:0] go_n, res_n, halt_n;
        logic exc_n;
        logic [DATA_W-1:0] rd_n;
        st = bus_req && bus_we;
        ok = bus_wdata < NH;
        id = bus_wdata[ID_W-1:0];
        go_n = m_go; res_n = m_res | dbg_resume_req; halt_n = m_halt;
        if (dbg_go_req && dbg_go_hart < NH) go_n[dbg_go_hart] = 1'b1;
        if (st && ok && bus_addr == 12'h104) go_n[id] = 1'b0;
        if (st && ok && bus_addr == 12'h108) begin res_n[id] = 1'b0; halt_n[id] = 1'b0; end
        if (st && ok && bus_addr == 12'h100) halt_n[id] = 1'b1;
        exc_n = (st && bus_addr == 12'h10C) ? 1'b1 : (dbg_exc_ack ? 1'b0 : m_exc);
        rd_n = (bus_req && !bus_we && bus_addr >= 12'h400) ? flag_word(bus_addr) : '0;
        @(posedge clk);
        @(negedge clk);
        m_go = go_n; m_res = res_n; m_halt = halt_n; m_exc = exc_n; m_rdata = rd_n;
        chk({tag, " R2/R5/R7 go"}, 32'(flag_go), 32'(m_go));
        chk({tag, " R3/R6/R7 resume"}, 32'(flag_resume), 32'(m_res));
        chk({tag, " R4/R6/R11 halted"}, 32'(hart_halted), 32'(m_halt));
        chk({tag, " R8 exception"}, 32'(dbg_exception), 32'(m_exc));
        chk({tag, " R9/R10 rdata"}, bus_rdata, m_rdata);
        idle_inputs();
    endtask

    task automatic hstore(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic hload(input logic [11:0] a);
        bus_req = 1; bus_we = 0; bus_addr = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 go", 32'(flag_go), 0);
        chk("R1 resume", 32'(flag_resume), 0);
        chk("R1 halted", 32'(hart_halted), 0);
        chk("R1 exc", 32'(dbg_exception), 0);
        chk("R1 rdata", bus_rdata, 0);
        rst_n = 1;
        @(negedge clk);

        // directed: halt hart 2, GO, read back, going ack
        hstore(12'h100, 2); tick("R4 halt h2");
        dbg_go_req = 1; dbg_go_hart = 2; tick("R2 go h2");
        hload(12'h402); tick("R9 read word0");
        hstore(12'h104, 2); tick("R5 going h2");
        // R7: set and clear same cycle
        dbg_go_req = 1; dbg_go_hart = 3; hstore(12'h104, 3); tick("R7 go collide");
        dbg_resume_req = 6'b100001; hstore(12'h108, 0); tick("R7 resume collide");
        // R3 several at once
        dbg_resume_req = 6'b011110; tick("R3 multi resume");
        hload(12'h404); tick("R9 word1 empty lanes");
        // R11 out of range ids
        hstore(12'h100, 6); tick("R11 halt id6");
        hstore(12'h108, 32'h0000_0102); tick("R11 resuming big id");
        // R10 stores to flag array / unlisted; reads elsewhere
        hstore(12'h401, 0); tick("R10 store flags");
        hstore(12'h200, 1); tick("R10 store unlisted");
        hload(12'h108); tick("R10 read elsewhere");
        // R6 resuming clears resume and halted
        hstore(12'h108, 2); tick("R6 resuming h2");
        // R8 exception, sticky, collide with ack, then ack
        hstore(12'h10C, 32'hDEAD_BEEF); tick("R8 exc raise");
        tick("R8 exc hold");
        hstore(12'h10C, 0); dbg_exc_ack = 1; tick("R8 exc vs ack");
        dbg_exc_ack = 1; tick("R8 exc ack");

        // random phase
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            logic [31:0] rid = $urandom_range(0, 7);
            case (op)
                0: hstore(12'h100, rid);
                1: hstore(12'h104, rid);
                2: hstore(12'h108, rid);
                3: hstore(12'h10C, $urandom);
                4: hload(12'h400 + 12'($urandom_range(0, 7)));
                5: hload(12'($urandom_range(0, 12'h3FF)));
                6: hstore(12'($urandom_range(0, 12'hFFF)) | 12'h400, rid);
                default: ;
            endcase
            if ($urandom_range(0, 3) == 0) begin
                dbg_go_req = 1; dbg_go_hart = ID_W'($urandom_range(0, NH - 1));
            end
            if ($urandom_range(0, 3) == 0) dbg_resume_req = NH'($urandom) & NH'($urandom);
            if ($urandom_range(0, 5) == 0) dbg_exc_ack = 1;
            tick("rand");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule